// File: doc/BRIEF.md
# Port-Bound Micro-op Dispatch Scheduler

This block sits between a micro-op reservation buffer and five execution ports. Every clock cycle it looks at the buffered entries that are both occupied and ready. For each port it picks the oldest entry whose operation class that port can run. Each picked entry is freed in the same cycle, so the allocator can reuse its slot in the next cycle. The outputs are one grant strobe per port, the index of the granted entry for each port, and a mask of freed slots.

The two integer ports are not equal. Port 0 holds the full integer unit and the floating-point unit. Port 1 runs only plain integer work: add, subtract and branch-target arithmetic. Ports 2, 3 and 4 take loads, store addresses and store data. A divide/square-root unit sits behind port 0. It is not pipelined, so the scheduler tracks how long it stays occupied. While it is occupied, no further divide or square root is granted. In the single cycle its result is written back, no pipelined floating-point add or multiply is granted either.

Entries are written through a one-per-cycle allocate port. A wake-up mask marks any number of entries ready at once.

Top module: `uop_dispatch_sched`

## Requirements
- R1: After reset every slot is empty. No grant strobe is set and the free mask is zero until entries are allocated.
- R2: An entry can be granted only when it is occupied and ready. An entry written with `alloc_rdy`=0 waits until a `wake_mask` bit sets it ready. A granted entry shows in `free_mask`, is empty in the next cycle, and can be refilled from that cycle on.
- R3: Among eligible entries for one port, the entry with the numerically smallest age tag is granted. Age tags of live entries are unique.
- R4: Class codes 6 (load), 7 (store address) and 8 (store data) are granted only on ports 2, 3 and 4 respectively, at most one per port per cycle.
- R5: Class codes 1 (shift, multiply, integer divide, address calculation), 2 (FP add), 3 (FP multiply), 4 (FP divide) and 5 (FP square root) are granted only on port 0. Port 0 grants at most one micro-op per cycle.
- R6: Class code 0 (plain integer) may go to either integer port. If port 0 has a class 1–5 candidate, the oldest class 0 entry goes to port 1. Otherwise the oldest class 0 entry goes to port 0 and the second oldest goes to port 1.
- R7: FP add and FP multiply are pipelined. When no write-back conflict exists, one may be granted on port 0 in every consecutive cycle.
- R8: A granted divide or square root occupies the divider for L cycles. No further class 4/5 grant happens until L+1 cycles after that grant. `alloc_prec` selects L: 0 single, 1 double, 2 or 3 extended. Divide takes 18/27/36 cycles; square root takes 29/49/69 cycles.
- R9: In the last occupied cycle, which is the divider's write-back cycle, port 0 grants no FP add or multiply. A class 0 or class 1 entry may still be granted on port 0 in that cycle.
- R10: All five ports may grant in the same cycle, and no two ports ever grant the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_en | input | 1 | Write one entry this cycle |
| alloc_idx | input | IW | Slot to write |
| alloc_cls | input | 4 | Operation class code |
| alloc_prec | input | 2 | Precision for divide/square root |
| alloc_age | input | AW | Age tag, smaller is older |
| alloc_rdy | input | 1 | Entry is ready on arrival |
| wake_mask | input | DEPTH | Marks the selected entries ready |
| gnt | output | 5 | Grant strobe per port |
| gnt_idx | output | 5×IW | Granted slot per port |
| free_mask | output | DEPTH | Slots freed this cycle |

## Verification
Two functions can land in the same cycle: the divider's write-back slot and the pipelined FP add stream on port 0. The bench queues a double divide, an extended square root and a single divide back to back. It keeps a fresh FP add arriving every cycle, so an add is always waiting when the write-back cycle comes. In that cycle port 0 must not grant an add. The waiting add must go out in the next cycle, and the spacing between divider grants must equal each latency plus one.

// File: rtl/uop_sched_pkg.sv
package uop_sched_pkg;

  localparam int NPORT = 5;
  localparam int LAT_W = 7;

  typedef enum logic [3:0] {
    UC_ALU   = 4'd0,
    UC_CPX   = 4'd1,
    UC_FADD  = 4'd2,
    UC_FMUL  = 4'd3,
    UC_FDIV  = 4'd4,
    UC_FSQRT = 4'd5,
    UC_LOAD  = 4'd6,
    UC_STA   = 4'd7,
    UC_STD   = 4'd8
  } uop_cls_e;

  // classes that only the full-function port can run
  function automatic logic port0_only(input uop_cls_e c);
    return (c == UC_CPX) || (c == UC_FADD) || (c == UC_FMUL) ||
           (c == UC_FDIV) || (c == UC_FSQRT);
  endfunction

  function automatic logic fp_pipelined(input uop_cls_e c);
    return (c == UC_FADD) || (c == UC_FMUL);
  endfunction

  function automatic logic long_op(input uop_cls_e c);
    return (c == UC_FDIV) || (c == UC_FSQRT);
  endfunction

  // memory port k (0..2) serves class LOAD+k
  function automatic uop_cls_e mem_class(input int k);
    return uop_cls_e'(4'(int'(UC_LOAD) + k));
  endfunction

  // occupancy of the divider in cycles
  function automatic logic [LAT_W-1:0] long_latency(input uop_cls_e c,
                                                    input logic [1:0] prec);
    logic [LAT_W-1:0] l;
    if (c == UC_FSQRT) begin
      case (prec)
        2'd0:    l = 7'd29;
        2'd1:    l = 7'd49;
        default: l = 7'd69;
      endcase
    end else begin
      case (prec)
        2'd0:    l = 7'd18;
        2'd1:    l = 7'd27;
        default: l = 7'd36;
      endcase
    end
    return l;
  endfunction

endpackage

// File: rtl/uop_age_pick.sv
module uop_age_pick #(
  parameter int DEPTH = 16,
  parameter int AW    = 10,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] mask,
  input  logic [AW-1:0]    age [DEPTH],
  output logic             found,
  output logic [IW-1:0]    idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (mask[i] && (!found || age[i] < age[idx])) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/uop_div_occupancy.sv
module uop_div_occupancy
  import uop_sched_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LAT_W-1:0] lat,
  output logic             busy,
  output logic             wb_cycle
);

  logic [LAT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)              remain <= '0;
    else if (start)          remain <= lat;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign busy     = (remain != '0);
  assign wb_cycle = (remain == LAT_W'(1));

endmodule

// File: rtl/uop_entry_file.sv
module uop_entry_file
  import uop_sched_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 10,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [IW-1:0]    alloc_idx,
  input  uop_cls_e         alloc_cls,
  input  logic [1:0]       alloc_prec,
  input  logic [AW-1:0]    alloc_age,
  input  logic             alloc_rdy,
  input  logic [DEPTH-1:0] wake_mask,
  input  logic [DEPTH-1:0] clear_mask,
  output logic [DEPTH-1:0] ent_v,
  output logic [DEPTH-1:0] ent_r,
  output uop_cls_e         ent_cls  [DEPTH],
  output logic [1:0]       ent_prec [DEPTH],
  output logic [AW-1:0]    ent_age  [DEPTH]
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    wire wr_here = alloc_en && (alloc_idx == IW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_v[i]    <= 1'b0;
        ent_r[i]    <= 1'b0;
        ent_cls[i]  <= UC_ALU;
        ent_prec[i] <= 2'd0;
        ent_age[i]  <= '0;
      end else if (wr_here) begin
        ent_v[i]    <= 1'b1;
        ent_r[i]    <= alloc_rdy;
        ent_cls[i]  <= alloc_cls;
        ent_prec[i] <= alloc_prec;
        ent_age[i]  <= alloc_age;
      end else begin
        if (clear_mask[i]) ent_v[i] <= 1'b0;
        if (wake_mask[i])  ent_r[i] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/uop_dispatch_sched.sv
module uop_dispatch_sched
  import uop_sched_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 10,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        alloc_en,
  input  logic [IW-1:0]               alloc_idx,
  input  logic [3:0]                  alloc_cls,
  input  logic [1:0]                  alloc_prec,
  input  logic [AW-1:0]               alloc_age,
  input  logic                        alloc_rdy,
  input  logic [DEPTH-1:0]            wake_mask,
  output logic [NPORT-1:0]            gnt,
  output logic [NPORT-1:0][IW-1:0]    gnt_idx,
  output logic [DEPTH-1:0]            free_mask
);

  localparam int NMEM = 3;

  logic [DEPTH-1:0] ent_v, ent_r;
  uop_cls_e         ent_cls  [DEPTH];
  logic [1:0]       ent_prec [DEPTH];
  logic [AW-1:0]    ent_age  [DEPTH];

  logic div_busy, div_wb, div_start;
  logic [LAT_W-1:0] div_lat;

  // eligibility masks
  logic [DEPTH-1:0] m_p0, m_alu, m_alu_b;
  logic [DEPTH-1:0] m_mem [NMEM];

  logic          p0_found, alu_a_found, alu_b_found;
  logic [IW-1:0] p0_idx, alu_a_idx, alu_b_idx;
  logic [NMEM-1:0] mem_found;
  logic [IW-1:0]   mem_idx [NMEM];

  uop_entry_file #(.DEPTH(DEPTH), .AW(AW)) u_entries (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(alloc_en), .alloc_idx(alloc_idx),
    .alloc_cls(uop_cls_e'(alloc_cls)), .alloc_prec(alloc_prec),
    .alloc_age(alloc_age), .alloc_rdy(alloc_rdy),
    .wake_mask(wake_mask), .clear_mask(free_mask),
    .ent_v(ent_v), .ent_r(ent_r), .ent_cls(ent_cls),
    .ent_prec(ent_prec), .ent_age(ent_age)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_elig
    wire live = ent_v[i] & ent_r[i];
    assign m_p0[i]  = live & port0_only(ent_cls[i])
                    & ~(long_op(ent_cls[i]) & div_busy)
                    & ~(fp_pipelined(ent_cls[i]) & div_wb);
    assign m_alu[i] = live & (ent_cls[i] == UC_ALU);
    assign m_alu_b[i] = m_alu[i] & ~(alu_a_found & (alu_a_idx == IW'(i)));
    for (genvar k = 0; k < NMEM; k++) begin : g_mem
      assign m_mem[k][i] = live & (ent_cls[i] == mem_class(k));
    end
  end

  uop_age_pick #(.DEPTH(DEPTH), .AW(AW)) u_pick_p0 (
    .mask(m_p0), .age(ent_age), .found(p0_found), .idx(p0_idx));
  uop_age_pick #(.DEPTH(DEPTH), .AW(AW)) u_pick_alu_a (
    .mask(m_alu), .age(ent_age), .found(alu_a_found), .idx(alu_a_idx));
  uop_age_pick #(.DEPTH(DEPTH), .AW(AW)) u_pick_alu_b (
    .mask(m_alu_b), .age(ent_age), .found(alu_b_found), .idx(alu_b_idx));

  for (genvar k = 0; k < NMEM; k++) begin : g_mem_pick
    uop_age_pick #(.DEPTH(DEPTH), .AW(AW)) u_pick (
      .mask(m_mem[k]), .age(ent_age), .found(mem_found[k]), .idx(mem_idx[k]));
  end

  // port steering
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    if (p0_found) begin
      gnt[0]     = 1'b1;
      gnt_idx[0] = p0_idx;
      gnt[1]     = alu_a_found;
      gnt_idx[1] = alu_a_found ? alu_a_idx : '0;
    end else begin
      gnt[0]     = alu_a_found;
      gnt_idx[0] = alu_a_found ? alu_a_idx : '0;
      gnt[1]     = alu_b_found;
      gnt_idx[1] = alu_b_found ? alu_b_idx : '0;
    end
    for (int k = 0; k < NMEM; k++) begin
      gnt[2+k]     = mem_found[k];
      gnt_idx[2+k] = mem_found[k] ? mem_idx[k] : '0;
    end
  end

  always_comb begin
    free_mask = '0;
    for (int p = 0; p < NPORT; p++)
      if (gnt[p]) free_mask[gnt_idx[p]] = 1'b1;
  end

  assign div_start = p0_found & long_op(ent_cls[p0_idx]);
  assign div_lat   = long_latency(ent_cls[p0_idx], ent_prec[p0_idx]);

  uop_div_occupancy u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .lat(div_lat),
    .busy(div_busy), .wb_cycle(div_wb));

endmodule

// File: rtl/uop_sched_checker.sv
module uop_sched_checker
  import uop_sched_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NPORT-1:0]         gnt,
  input logic [NPORT-1:0][IW-1:0] gnt_idx,
  input logic [DEPTH-1:0]         ent_v,
  input logic [DEPTH-1:0]         ent_r,
  input uop_cls_e                 ent_cls [DEPTH],
  input logic                     div_busy,
  input logic                     div_wb,
  input logic                     alloc_en,
  input logic [IW-1:0]            alloc_idx
);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assert_granted_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[p] |-> (ent_v[gnt_idx[p]] && ent_r[gnt_idx[p]]));

    assert_freed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[p] && !(alloc_en && alloc_idx == gnt_idx[p]) |=> !ent_v[$past(gnt_idx[p])]);

    for (genvar q = p + 1; q < NPORT; q++) begin : g_pair
      assert_distinct_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt[p] && gnt[q]) |-> (gnt_idx[p] != gnt_idx[q]));
    end
  end

  assert_port1_alu_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[1] |-> (ent_cls[gnt_idx[1]] == UC_ALU));

  assert_load_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[2] |-> (ent_cls[gnt_idx[2]] == UC_LOAD));
  assert_sta_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[3] |-> (ent_cls[gnt_idx[3]] == UC_STA));
  assert_std_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[4] |-> (ent_cls[gnt_idx[4]] == UC_STD));

  assert_port0_class_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[0] |-> (ent_cls[gnt_idx[0]] <= UC_FSQRT));

  assert_div_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[0] && (ent_cls[gnt_idx[0]] == UC_FDIV || ent_cls[gnt_idx[0]] == UC_FSQRT))
      |-> !div_busy);

  assert_div_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[0] && (ent_cls[gnt_idx[0]] == UC_FDIV || ent_cls[gnt_idx[0]] == UC_FSQRT))
      |=> div_busy);

  assert_wb_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[0] && div_wb) |->
      !(ent_cls[gnt_idx[0]] == UC_FADD || ent_cls[gnt_idx[0]] == UC_FMUL));

endmodule

bind uop_dispatch_sched uop_sched_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .gnt(gnt), .gnt_idx(gnt_idx),
  .ent_v(ent_v), .ent_r(ent_r), .ent_cls(ent_cls),
  .div_busy(div_busy), .div_wb(div_wb),
  .alloc_en(alloc_en), .alloc_idx(alloc_idx)
);

// File: tb/uop_dispatch_sched_test.sv
`timescale 1ns/1ps
module uop_dispatch_sched_test;

  localparam int DEPTH = 16;
  localparam int AW    = 10;
  localparam int IW    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_en = 1'b0;
  logic [IW-1:0] alloc_idx = '0;
  logic [3:0] alloc_cls = '0;
  logic [1:0] alloc_prec = '0;
  logic [AW-1:0] alloc_age = '0;
  logic alloc_rdy = 1'b0;
  logic [DEPTH-1:0] wake_mask = '0;
  logic [4:0] gnt;
  logic [4:0][IW-1:0] gnt_idx;
  logic [DEPTH-1:0] free_mask;

  always #2.5 clk = ~clk;

  uop_dispatch_sched #(.DEPTH(DEPTH), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en), .alloc_idx(alloc_idx),
    .alloc_cls(alloc_cls), .alloc_prec(alloc_prec), .alloc_age(alloc_age),
    .alloc_rdy(alloc_rdy), .wake_mask(wake_mask),
    .gnt(gnt), .gnt_idx(gnt_idx), .free_mask(free_mask));

  int n_chk = 0, n_bad = 0, cyc = 0, next_age = 1;
  string cur_req = "R1";
  bit done = 0;

  // bench-side picture of the buffer
  bit m_v[DEPTH], m_r[DEPTH];
  int m_c[DEPTH], m_p[DEPTH], m_a[DEPTH];
  int m_cnt = 0;

  typedef struct packed { logic [4:0] g; logic [4:0][IW-1:0] ix; } exp_t;
  exp_t exp_q[$];

  int long_gnt[$];
  int fp_grants = 0;

  function automatic int lat_of(int c, int p);
    int dv[3] = '{18, 27, 36};
    int sq[3] = '{29, 49, 69};
    int k = (p > 2) ? 2 : p;
    return (c == 5) ? sq[k] : dv[k];
  endfunction

  function automatic int oldest(bit [DEPTH-1:0] cand);
    int best = -1;
    for (int i = 0; i < DEPTH; i++)
      if (cand[i] && (best < 0 || m_a[i] < m_a[best])) best = i;
    return best;
  endfunction

  function automatic exp_t predict();
    exp_t e;
    bit [DEPTH-1:0] c0, ca, cm[3];
    int p0, a, b, mi;
    e = '0;
    for (int i = 0; i < DEPTH; i++) begin
      bit ok = m_v[i] && m_r[i];
      c0[i] = ok && m_c[i] >= 1 && m_c[i] <= 5
              && !(m_c[i] >= 4 && m_cnt != 0)
              && !((m_c[i] == 2 || m_c[i] == 3) && m_cnt == 1);
      ca[i] = ok && m_c[i] == 0;
      for (int k = 0; k < 3; k++) cm[k][i] = ok && m_c[i] == 6 + k;
    end
    p0 = oldest(c0);
    a  = oldest(ca);
    if (a >= 0) ca[a] = 1'b0;
    b  = oldest(ca);
    if (p0 >= 0) begin
      e.g[0] = 1; e.ix[0] = IW'(p0);
      if (a >= 0) begin e.g[1] = 1; e.ix[1] = IW'(a); end
    end else begin
      if (a >= 0) begin e.g[0] = 1; e.ix[0] = IW'(a); end
      if (b >= 0) begin e.g[1] = 1; e.ix[1] = IW'(b); end
    end
    for (int k = 0; k < 3; k++) begin
      mi = oldest(cm[k]);
      if (mi >= 0) begin e.g[2+k] = 1; e.ix[2+k] = IW'(mi); end
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // one cycle: driver pushes prediction, monitor pops and compares, model advances
  task automatic tick();
    exp_t e, got;
    logic [DEPTH-1:0] fm;
    bit long_go;
    int lat_new;
    exp_q.push_back(predict());
    e = exp_q.pop_front();
    got.g = gnt; got.ix = gnt_idx;
    fm = '0;
    for (int p = 0; p < 5; p++) if (e.g[p]) fm[e.ix[p]] = 1'b1;
    check(got == e, cur_req, "grants", got, e);
    check(free_mask == fm, cur_req, "free_mask", free_mask, fm);
    if (m_cnt == 1 && gnt[0])
      check(!(m_c[gnt_idx[0]] == 2 || m_c[gnt_idx[0]] == 3), "R9",
            "fp issue in writeback cycle", m_c[gnt_idx[0]], 0);
    if (gnt[0] && m_c[gnt_idx[0]] >= 4 && m_c[gnt_idx[0]] <= 5) long_gnt.push_back(cyc);
    if (gnt[0] && (m_c[gnt_idx[0]] == 2 || m_c[gnt_idx[0]] == 3)) fp_grants++;
    long_go = e.g[0] && m_c[e.ix[0]] >= 4 && m_c[e.ix[0]] <= 5;
    lat_new = long_go ? lat_of(m_c[e.ix[0]], m_p[e.ix[0]]) : 0;
    for (int p = 0; p < 5; p++) if (e.g[p]) m_v[e.ix[p]] = 0;
    if (long_go) m_cnt = lat_new; else if (m_cnt > 0) m_cnt--;
    for (int i = 0; i < DEPTH; i++) begin
      if (alloc_en && alloc_idx == IW'(i)) begin
        m_v[i] = 1; m_r[i] = alloc_rdy; m_c[i] = int'(alloc_cls);
        m_p[i] = int'(alloc_prec); m_a[i] = int'(alloc_age);
      end else if (wake_mask[i]) m_r[i] = 1;
    end
    @(posedge clk);
    #1;
    alloc_en = 0; wake_mask = '0;
    cyc++;
    @(negedge clk);
  endtask

  task automatic put(input int c, input int p, input bit rdy, output int slot);
    slot = -1;
    for (int i = 0; i < DEPTH; i++) if (!m_v[i] && slot < 0) slot = i;
    if (slot >= 0) begin
      alloc_en = 1; alloc_idx = IW'(slot); alloc_cls = 4'(c);
      alloc_prec = 2'(p); alloc_age = AW'(next_age); alloc_rdy = rdy;
      next_age++;
    end
  endtask

  task automatic put_aged(input int slot, input int c, input int age, input bit rdy);
    alloc_en = 1; alloc_idx = IW'(slot); alloc_cls = 4'(c);
    alloc_prec = 0; alloc_age = AW'(age); alloc_rdy = rdy;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int s, s1, s2, s3, s4, s5;
    int fp0;
    for (int i = 0; i < DEPTH; i++) begin m_v[i] = 0; m_r[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(gnt == 0, "R1", "gnt in reset", gnt, 0);
    check(free_mask == 0, "R1", "free_mask in reset", free_mask, 0);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    tick(); tick();

    // R10 / R4: five classes become ready together
    cur_req = "R10";
    put(6, 0, 0, s1); tick();
    put(7, 0, 0, s2); tick();
    put(8, 0, 0, s3); tick();
    put(0, 0, 0, s4); tick();
    put(2, 0, 0, s5); tick();
    wake_mask = '0;
    wake_mask[s1] = 1; wake_mask[s2] = 1; wake_mask[s3] = 1;
    wake_mask[s4] = 1; wake_mask[s5] = 1;
    tick();
    check(gnt == 5'h1F, "R10", "all five ports", gnt, 5'h1F);
    check(gnt_idx[2] == IW'(s1) && gnt_idx[3] == IW'(s2) && gnt_idx[4] == IW'(s3),
          "R4", "memory port slots", gnt_idx, 0);
    tick();

    // R3 / R6: three plain integer ops, age order differs from slot order
    cur_req = "R3";
    put_aged(5, 0, 40, 0); tick();
    put_aged(6, 0, 30, 0); tick();
    put_aged(7, 0, 35, 0); tick();
    wake_mask = 16'h00E0; tick();
    check(gnt[1:0] == 2'b11 && gnt_idx[0] == 4'd6 && gnt_idx[1] == 4'd7,
          "R3", "oldest two integer ops", gnt_idx[1:0], {4'd7, 4'd6});
    tick();
    check(gnt[0] && gnt_idx[0] == 4'd5 && !gnt[1], "R6", "last integer op on port 0",
          {gnt, gnt_idx[0]}, {5'b00001, 4'd5});
    tick();

    // R5 / R6: port-0-only op pushes the oldest integer op to port 1
    cur_req = "R5";
    put_aged(8, 0, 50, 0); tick();
    put_aged(9, 1, 60, 0); tick();
    put_aged(10, 0, 45, 0); tick();
    wake_mask = 16'h0700; tick();
    check(gnt[0] && gnt_idx[0] == 4'd9, "R5", "complex op on port 0", gnt_idx[0], 9);
    check(gnt[1] && gnt_idx[1] == 4'd10, "R6", "oldest integer op on port 1", gnt_idx[1], 10);
    tick(); tick();

    // R2: not-ready entry waits for wake-up, slot then reused
    cur_req = "R2";
    put_aged(3, 6, 70, 0); tick();
    repeat (3) begin
      check(gnt[2] == 0, "R2", "not-ready load granted", gnt[2], 0);
      tick();
    end
    wake_mask = 16'h0008; tick();
    check(gnt[2] && gnt_idx[2] == 4'd3, "R2", "woken load", gnt_idx[2], 3);
    check(free_mask == 16'h0008, "R2", "free mask", free_mask, 16'h0008);
    tick();
    put_aged(3, 7, 71, 1); tick();
    check(gnt[3] && gnt_idx[3] == 4'd3, "R2", "refilled slot", gnt_idx[3], 3);
    tick();

    // R7: pipelined FP ops every cycle
    cur_req = "R7";
    fp0 = fp_grants;
    for (int k = 0; k < 6; k++) begin
      put((k % 2 == 0) ? 2 : 3, 0, 1, s); tick();
    end
    tick();
    check(fp_grants - fp0 == 6, "R7", "back-to-back FP grants", fp_grants - fp0, 6);

    // R8 / R9: divider occupancy against a steady FP add stream
    cur_req = "R8";
    long_gnt.delete();
    put(4, 1, 1, s); tick();
    put(5, 2, 1, s); tick();
    put(4, 0, 1, s); tick();
    cur_req = "R9";
    for (int k = 0; k < 130; k++) begin
      put(2, 0, 1, s); tick();
    end
    repeat (4) tick();
    check(long_gnt.size() == 3, "R8", "divider grant count", long_gnt.size(), 3);
    if (long_gnt.size() == 3) begin
      check(long_gnt[1] - long_gnt[0] == 28, "R8", "double divide spacing",
            long_gnt[1] - long_gnt[0], 28);
      check(long_gnt[2] - long_gnt[1] == 70, "R8", "extended sqrt spacing",
            long_gnt[2] - long_gnt[1], 70);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule